// File: doc/BRIEF.md
# Twisted-Pair Receive Polarity Corrector

This block decides whether the receive pair of a twisted-pair port is wired the wrong way round. When it is, the block inverts the receive data stream so that the decoder downstream sees correct data. Two sources feed the decision. The first is the polarity of the link pulses that qualified the port for link pass, which gives an initial setting. The second is the polarity of each frame's end delimiter, reported once per frame by the delimiter recogniser. Pulse qualification, delimiter recognition and the link state machine sit outside this block. They reach it as strobes and level inputs.

After reset, and after every link-fail event, the decision is open ("armed"). In that state each frame whose delimiter is valid may override the setting. The first such frame always imposes its polarity. A later one that agrees with the current setting freezes it. A later one that disagrees replaces the setting and the block stays open. Once frozen, the setting holds until the next link fail or reset. The corrected data is the raw data XORed with the reversed indicator on every lane, with no added latency. The indicator itself is registered.

Top module: `rxpol_corrector`

## Requirements
- R1: After reset, `pol_rev` is 0 and the block is armed with no frame counted. The first valid frame is therefore always taken.
- R2: While armed, a cycle with `linkup_stb` high loads `linkup_pol` into `pol_rev`. A value of 1 means reversed.
- R3: While armed with no frame counted since arming, a frame report with `frm_etd_ok`=1 sets `pol_rev` to `frm_pol`, whatever `pol_rev` was. That frame then counts as seen.
- R4: While armed with a frame already counted, a valid frame with `frm_pol` equal to `pol_rev` freezes the decision. `pol_rev` is unchanged.
- R5: While armed with a frame already counted, a valid frame with `frm_pol` different from `pol_rev` sets `pol_rev` to `frm_pol`. The block stays armed, so the next agreeing valid frame freezes it.
- R6: A frame report with `frm_etd_ok`=0 changes neither `pol_rev` nor the count of seen frames.
- R7: Once frozen, frame reports and `linkup_stb` leave `pol_rev` unchanged until `link_fail` or reset.
- R8: A cycle with `link_fail` high re-arms the block and clears the seen count. It leaves `pol_rev` at its value.
- R9: Within one cycle, `link_fail` overrides `linkup_stb`, and `linkup_stb` overrides a frame report. The overridden input has no effect.
- R10: `rx_dout[i]` equals `rx_din[i]` XOR `pol_rev` on every lane, in the same cycle.
- R11: Every state change takes effect on the clock edge that samples the strobe. `pol_rev` reflects it from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_fail | input | 1 | Link-fail event or level; re-arms the decision |
| linkup_stb | input | 1 | One-cycle strobe on entry to link pass |
| linkup_pol | input | 1 | Polarity of the qualifying link pulses (1 = reversed) |
| frm_stb | input | 1 | One-cycle end-of-frame report strobe |
| frm_etd_ok | input | 1 | End delimiter of the reported frame was valid |
| frm_pol | input | 1 | Polarity of that delimiter (1 = reversed) |
| rx_din | input | LANES | Raw receive data |
| pol_rev | output | 1 | Reversed-polarity indicator |
| rx_dout | output | LANES | Polarity-corrected receive data |

## Verification
Every strobe is sampled on one rising edge and moves `pol_rev` on that same edge, so its effect is due one cycle after the strobe. The bench drives each strobe for a single cycle from a falling edge and compares `pol_rev` at the next falling edge. `rx_dout` is combinational, so it is checked a short delay after `rx_din` changes, with no edge in between. Whether the block is armed or frozen is never read from inside. The bench probes it through the ports: it sends an opposing valid frame and checks whether `pol_rev` moves one cycle later.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

    typedef enum logic [1:0] {
        EVT_NONE   = 2'd0,
        EVT_FAIL   = 2'd1,
        EVT_LINKUP = 2'd2,
        EVT_FRAME  = 2'd3
    } rxpol_evt_e;

    typedef struct packed {
        logic inv;
        logic armed;
        logic seen;
    } rxpol_state_t;

    localparam rxpol_state_t RXPOL_RST = '{inv: 1'b0, armed: 1'b1, seen: 1'b0};

endpackage

// File: rtl/rxpol_evt_sel.sv
module rxpol_evt_sel
    import rxpol_pkg::*;
(
    input  logic       link_fail,
    input  logic       linkup_stb,
    input  logic       frm_stb,
    input  logic       frm_etd_ok,
    output rxpol_evt_e evt
);

    // Fixed priority: fail, then link-up, then a valid-delimiter frame.
    always_comb begin
        if (link_fail)
            evt = EVT_FAIL;
        else if (linkup_stb)
            evt = EVT_LINKUP;
        else if (frm_stb && frm_etd_ok)
            evt = EVT_FRAME;
        else
            evt = EVT_NONE;
    end

endmodule

// File: rtl/rxpol_decider.sv
module rxpol_decider
    import rxpol_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rxpol_evt_e evt,
    input  logic       linkup_pol,
    input  logic       frame_pol,
    output logic       inv,
    output logic       armed,
    output logic       seen
);

    rxpol_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (evt)
            EVT_FAIL: begin
                st_d.armed = 1'b1;
                st_d.seen  = 1'b0;
            end
            EVT_LINKUP: begin
                if (st_q.armed)
                    st_d.inv = linkup_pol;
            end
            EVT_FRAME: begin
                if (st_q.armed) begin
                    if (!st_q.seen) begin
                        st_d.inv  = frame_pol;
                        st_d.seen = 1'b1;
                    end else if (frame_pol == st_q.inv) begin
                        st_d.armed = 1'b0;
                    end else begin
                        st_d.inv = frame_pol;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= RXPOL_RST;
        else
            st_q <= st_d;
    end

    assign inv   = st_q.inv;
    assign armed = st_q.armed;
    assign seen  = st_q.seen;

endmodule

// File: rtl/rxpol_lane_fix.sv
module rxpol_lane_fix #(
    parameter int LANES = 1
) (
    input  logic             inv,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] dout
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g] = din[g] ^ inv;
    end

endmodule

// File: rtl/rxpol_corrector.sv
module rxpol_corrector
    import rxpol_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_fail,
    input  logic             linkup_stb,
    input  logic             linkup_pol,
    input  logic             frm_stb,
    input  logic             frm_etd_ok,
    input  logic             frm_pol,
    input  logic [LANES-1:0] rx_din,
    output logic             pol_rev,
    output logic [LANES-1:0] rx_dout
);

    rxpol_evt_e evt_w;
    logic       armed_w;
    logic       seen_w;

    rxpol_evt_sel u_sel (
        .link_fail  (link_fail),
        .linkup_stb (linkup_stb),
        .frm_stb    (frm_stb),
        .frm_etd_ok (frm_etd_ok),
        .evt        (evt_w)
    );

    rxpol_decider u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_w),
        .linkup_pol (linkup_pol),
        .frame_pol  (frm_pol),
        .inv        (pol_rev),
        .armed      (armed_w),
        .seen       (seen_w)
    );

    rxpol_lane_fix #(.LANES(LANES)) u_fix (
        .inv  (pol_rev),
        .din  (rx_din),
        .dout (rx_dout)
    );

endmodule

// File: rtl/rxpol_chk.sv
module rxpol_chk (
    input logic clk,
    input logic rst_n,
    input logic link_fail,
    input logic linkup_stb,
    input logic linkup_pol,
    input logic frm_stb,
    input logic frm_etd_ok,
    input logic frm_pol,
    input logic pol_rev,
    input logic armed,
    input logic seen
);

    logic quiet_hi;
    assign quiet_hi = !link_fail && !linkup_stb;

    AST_FAIL_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail |=> (armed && !seen)) else $error("rearm");              // R8
    AST_FAIL_KEEPS_POL: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail |=> $stable(pol_rev)) else $error("fail pol");           // R8
    AST_LINKUP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && linkup_stb && !link_fail) |=> (pol_rev == $past(linkup_pol))) else $error("linkup"); // R2
    AST_FIRST_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !seen && quiet_hi && frm_stb && frm_etd_ok)
        |=> (pol_rev == $past(frm_pol) && seen)) else $error("first");      // R3
    AST_AGREE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && seen && quiet_hi && frm_stb && frm_etd_ok && frm_pol == pol_rev)
        |=> (!armed && $stable(pol_rev))) else $error("lock");              // R4
    AST_DISAGREE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && seen && quiet_hi && frm_stb && frm_etd_ok && frm_pol != pol_rev)
        |=> (armed && pol_rev == $past(frm_pol))) else $error("disagree");  // R5
    AST_BAD_ETD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_hi && frm_stb && !frm_etd_ok)
        |=> ($stable(pol_rev) && $stable(seen) && $stable(armed))) else $error("bad etd"); // R6
    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !link_fail) |=> ($stable(pol_rev) && !armed)) else $error("locked"); // R7

endmodule

bind rxpol_corrector rxpol_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_fail  (link_fail),
    .linkup_stb (linkup_stb),
    .linkup_pol (linkup_pol),
    .frm_stb    (frm_stb),
    .frm_etd_ok (frm_etd_ok),
    .frm_pol    (frm_pol),
    .pol_rev    (pol_rev),
    .armed      (armed_w),
    .seen       (seen_w)
);

// File: tb/rxpol_corrector_tb.sv
module rxpol_corrector_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             link_fail = 1'b0;
    logic             linkup_stb = 1'b0;
    logic             linkup_pol = 1'b0;
    logic             frm_stb = 1'b0;
    logic             frm_etd_ok = 1'b0;
    logic             frm_pol = 1'b0;
    logic [LANES-1:0] rx_din = '0;
    logic             pol_rev;
    logic [LANES-1:0] rx_dout;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // Model state taken from the requirements
    logic m_pol, m_armed, m_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxpol_corrector #(.LANES(LANES)) dut_i (
        .clk(clk), .rst_n(rst_n), .link_fail(link_fail),
        .linkup_stb(linkup_stb), .linkup_pol(linkup_pol),
        .frm_stb(frm_stb), .frm_etd_ok(frm_etd_ok), .frm_pol(frm_pol),
        .rx_din(rx_din), .pol_rev(pol_rev), .rx_dout(rx_dout)
    );

    task automatic chk(input string req, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Returns the requirement tag that governs this stimulus, updates the model.
    function automatic string model(input logic f, input logic ls, input logic lp,
                                    input logic fs, input logic fok, input logic fp);
        if (f) begin
            m_armed = 1'b1; m_seen = 1'b0;
            return (ls || fs) ? "R9" : "R8";
        end
        if (ls) begin
            if (m_armed) m_pol = lp;
            return fs ? "R9" : (m_armed ? "R2" : "R7");
        end
        if (!fs) return "R11";
        if (!fok) return "R6";
        if (!m_armed) return "R7";
        if (!m_seen) begin
            m_pol = fp; m_seen = 1'b1; return "R3";
        end
        if (fp == m_pol) begin
            m_armed = 1'b0; return "R4";
        end
        m_pol = fp;
        return "R5";
    endfunction

    // Drive one cycle of stimulus from a falling edge; check pol_rev at the next falling edge.
    task automatic step(input logic f, input logic ls, input logic lp,
                        input logic fs, input logic fok, input logic fp);
        string tag;
        link_fail = f; linkup_stb = ls; linkup_pol = lp;
        frm_stb = fs; frm_etd_ok = fok; frm_pol = fp;
        tag = model(f, ls, lp, fs, fok, fp);
        @(negedge clk);
        link_fail = 1'b0; linkup_stb = 1'b0; frm_stb = 1'b0;
        chk(tag, {{(LANES-1){1'b0}}, pol_rev}, {{(LANES-1){1'b0}}, m_pol});
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_pol = 1'b0; m_armed = 1'b1; m_seen = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", {{(LANES-1){1'b0}}, pol_rev}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {{(LANES-1){1'b0}}, pol_rev}, '0);
        // R1: first valid frame after reset is taken
        step(0, 0, 0, 1, 1, 1);

        // Sweep: every link-up polarity with every sequence of three frame reports
        for (int lp = 0; lp < 2; lp++) begin
            for (int code = 0; code < 64; code++) begin
                step(1, 0, 0, 0, 0, 0);
                step(0, 1, lp[0], 0, 0, 0);
                for (int e = 0; e < 3; e++)
                    step(0, 0, 0, 1, code[2*e+1], code[2*e]);
                // Probe armed/frozen: an opposing valid frame moves pol_rev only while armed
                step(0, 0, 0, 1, 1, ~m_pol);
                step(0, 0, 0, 1, 1, m_pol);
            end
        end

        // R7: frozen ignores link-up strobe and frames
        step(1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 1);
        step(0, 0, 0, 1, 1, 1);
        step(0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0);

        // R8/R9: held link fail with competing strobes keeps pol_rev, then re-arms
        for (int k = 0; k < 3; k++) step(1, 1, 0, 1, 1, 0);
        step(0, 0, 0, 1, 1, 0);

        // R9: link-up wins over a simultaneous frame, which leaves no count behind
        step(1, 0, 0, 0, 0, 0);
        step(0, 1, 1, 1, 1, 0);
        step(0, 0, 0, 1, 1, 0);
        step(0, 0, 0, 1, 1, 1);
        step(0, 0, 0, 1, 1, 1);

        // R10: lane correction in the same cycle, both polarities
        for (int p = 0; p < 2; p++) begin
            step(1, 0, 0, 0, 0, 0);
            step(0, 0, 0, 1, 1, p[0]);
            for (int d = 0; d < (1 << LANES); d++) begin
                rx_din = d[LANES-1:0];
                #1;
                chk("R10", rx_dout, d[LANES-1:0] ^ {LANES{p[0]}});
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule